// File: doc/BRIEF.md
# Programmable Baud-Rate Generator with Gated Divisor Latches

This block turns a synchronous baud-clock enable into a train of single-cycle pulses at sixteen times the serial bit rate. It also gives a bit-rate tick once every sixteen of those pulses. The division ratio is a 16-bit divisor that software programs through a byte-wide register port. The divisor is split across two byte latches.

The two latches share their register offsets with other serial-port registers. They are reachable only while the divisor-access bit (bit 7 of the line-control register, brought in as `dl_access`) is 1. While that bit is 0, a read at those offsets returns whatever the surrounding register file supplies on `ext_rdata`, and a write leaves the latches untouched. A divisor of zero halts both outputs.

Top module: `baud_gen_top`

## Requirements
- R1: After a synchronous active-low reset, the low latch reads 8'h02 and the high latch reads 8'h00, so the divisor is 2. Both outputs are low and both counters are zero.
- R2: The low latch sits at offset 0 and the high latch at offset 1. While `dl_access` is 1, a write at one of those offsets loads `bus_wdata` into that latch on the clock edge, and `bus_rdata` returns the latch value combinationally.
- R3: While `dl_access` is 0, a write at offset 0 or 1 leaves both latches unchanged.
- R4: `bus_rdata` returns `ext_rdata` at any offset other than 0 or 1. It also returns `ext_rdata` at offsets 0 and 1 while `dl_access` is 0.
- R5: With a nonzero divisor D, `x16_tick` is high for one cycle. It rises in the cycle after every D-th sampled `baud_ce`, counted from when the divisor was loaded.
- R6: When both latches are zero, `x16_tick` is low from the next cycle on, and the divide counter and the bit counter are cleared.
- R7: The divide counter takes a new latch value only when its count completes, or on the first cycle after a stop ends. On that first cycle no pulse is produced, and counting resumes from zero.
- R8: With a divisor of 1, every sampled `baud_ce` yields an `x16_tick` in the next cycle.
- R9: `bit_tick` is high exactly in the cycle of every 16th `x16_tick` since the last reset or stop. It never comes without `x16_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_ce | input | 1 | Baud input clock, as a synchronous enable |
| dl_access | input | 1 | Divisor-access bit from the line-control register |
| bus_addr | input | 3 | Register offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| ext_rdata | input | 8 | Read data from the other serial-port registers |
| bus_rdata | output | 8 | Read data |
| x16_tick | output | 1 | Pulse at sixteen times the bit rate |
| bit_tick | output | 1 | Pulse at the bit rate |

## Verification
A wrong latch value appears on `bus_rdata` at once, in the same cycle that the offset is presented with access enabled. A wrong divide count or a wrong reload shows as an `x16_tick` one cycle early or late, within one divisor period of `baud_ce` samples. A wrong bit counter shows up within sixteen `x16_tick` pulses, as a missing or misplaced `bit_tick`. The bench compares both tick outputs every cycle against a model that it derives from the requirements, so each of these faults is caught within those windows.

// File: rtl/baud_pkg.sv
// Shared widths and register offsets of the baud-rate generator.
package baud_pkg;
    localparam int BYTE_W = 8;
    localparam int DIV_W  = 2 * BYTE_W;
    typedef logic [BYTE_W-1:0] byte_t;
    localparam byte_t RESET_LO = 8'h02;
    localparam byte_t RESET_HI = 8'h00;
    localparam int OFS_LO = 0;
    localparam int OFS_HI = 1;
endpackage

// File: rtl/divisor_regs.sv
// Two divisor byte latches behind a gated register port.
// Assumes: reads are combinational; ungated accesses belong to other registers.
module divisor_regs
    import baud_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dl_access,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  byte_t             wdata,
    input  byte_t             ext_rdata,
    output byte_t             rdata,
    output logic [DIV_W-1:0]  divisor
);
    byte_t lo_q, hi_q;
    logic  sel_lo, sel_hi;

    assign sel_lo  = dl_access && (addr == ADDR_W'(OFS_LO));
    assign sel_hi  = dl_access && (addr == ADDR_W'(OFS_HI));
    assign divisor = {hi_q, lo_q};

    // Latch update on gated writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= RESET_LO;
            hi_q <= RESET_HI;
        end else begin
            if (we && sel_lo) lo_q <= wdata;
            if (we && sel_hi) hi_q <= wdata;
        end
    end

    // Read mux: latches when gated in, pass-through otherwise.
    always_comb begin
        if (sel_lo)      rdata = lo_q;
        else if (sel_hi) rdata = hi_q;
        else             rdata = ext_rdata;
    end

    // R3
    gated_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !dl_access) |=> ($stable(lo_q) && $stable(hi_q)));
    // R4
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dl_access |-> (rdata == ext_rdata));
endmodule

// File: rtl/rate_divider.sv
// Divides the baud enable by the divisor; emits a registered one-cycle pulse.
// Assumes: divisor is read live; a new value takes effect only at reload.
module rate_divider
    import baud_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             baud_ce,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick_o
);
    logic [DIV_W-1:0] active_q, cnt_q;
    logic             stop;

    assign stop = (divisor == '0);

    // Count enables; reload at expiry or when leaving the stopped state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= DIV_W'({RESET_HI, RESET_LO});
            cnt_q    <= '0;
            tick_o   <= 1'b0;
        end else if (stop) begin
            active_q <= '0;
            cnt_q    <= '0;
            tick_o   <= 1'b0;
        end else if (active_q == '0) begin
            active_q <= divisor;
            cnt_q    <= '0;
            tick_o   <= 1'b0;
        end else if (baud_ce) begin
            if (cnt_q == active_q - 1'b1) begin
                tick_o   <= 1'b1;
                cnt_q    <= '0;
                active_q <= divisor;
            end else begin
                tick_o   <= 1'b0;
                cnt_q    <= cnt_q + 1'b1;
            end
        end else begin
            tick_o <= 1'b0;
        end
    end

    // R6
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !tick_o);
    // R5
    tick_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tick_o) |-> $past(baud_ce));
    // R8
    div_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop && active_q == DIV_W'(1) && baud_ce) |=> tick_o);
endmodule

// File: rtl/tick_prescaler.sv
// Counts x16 pulses; flags the last of each group of 2**PRE_W.
// Assumes: clear_i holds the counter at zero while the generator is stopped.
module tick_prescaler #(
    parameter int PRE_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic step_i,
    output logic tick_o
);
    localparam logic [PRE_W-1:0] LAST = '1;
    logic [PRE_W-1:0] cnt_q;

    assign tick_o = step_i && (cnt_q == LAST);

    // Advance on each input pulse; clear on reset or stop.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) cnt_q <= '0;
        else if (step_i)       cnt_q <= cnt_q + 1'b1;
    end

    // R9
    bit_in_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> step_i);
    // R6
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (cnt_q == '0));
endmodule

// File: rtl/baud_gen_top.sv
// Baud-rate generator: gated divisor latches, divide counter, bit prescaler.
// Assumes: baud_ce and bus signals are synchronous to clk.
module baud_gen_top
    import baud_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int PRE_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_ce,
    input  logic              dl_access,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [7:0]        bus_wdata,
    input  logic [7:0]        ext_rdata,
    output logic [7:0]        bus_rdata,
    output logic              x16_tick,
    output logic              bit_tick
);
    logic [DIV_W-1:0] divisor;

    divisor_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .dl_access(dl_access), .addr(bus_addr),
        .we(bus_we), .wdata(bus_wdata), .ext_rdata(ext_rdata),
        .rdata(bus_rdata), .divisor(divisor)
    );

    rate_divider u_div (
        .clk(clk), .rst_n(rst_n), .baud_ce(baud_ce),
        .divisor(divisor), .tick_o(x16_tick)
    );

    tick_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .clear_i(divisor == '0),
        .step_i(x16_tick), .tick_o(bit_tick)
    );
endmodule

// File: tb/baud_gen_top_bench.sv
module baud_gen_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_ce = 1'b0;
    logic       dl_access = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] ext_rdata = 8'h5A;
    logic [7:0] bus_rdata;
    logic       x16_tick, bit_tick;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // reference state
    logic [7:0]  m_lo = 8'h02, m_hi = 8'h00;
    logic [15:0] m_act = 16'd2, m_cnt = '0;
    logic        m_tk = 1'b0;
    logic [3:0]  m_bc = '0;

    always #4 clk = ~clk;

    baud_gen_top u_baud_gen_top (
        .clk(clk), .rst_n(rst_n), .baud_ce(baud_ce), .dl_access(dl_access),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .ext_rdata(ext_rdata), .bus_rdata(bus_rdata),
        .x16_tick(x16_tick), .bit_tick(bit_tick)
    );

    // Expected read data, from R2 and R4.
    function automatic logic [7:0] exp_read(input logic acc, input logic [2:0] a,
                                            input logic [7:0] ext);
        if (acc && a == 3'd0) return m_lo;
        if (acc && a == 3'd1) return m_hi;
        return ext;
    endfunction

    // Expected bit tick, from R9.
    function automatic logic exp_bit();
        return m_tk && (m_bc == 4'hF);
    endfunction

    // Reference update per R1, R2, R3, R5-R9.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_lo = 8'h02; m_hi = 8'h00; m_act = 16'd2; m_cnt = '0; m_tk = 0; m_bc = '0;
        end else begin
            logic zero;
            zero = ({m_hi, m_lo} == 16'd0);
            if (zero) m_bc = '0;
            else if (m_tk) m_bc = m_bc + 1'b1;
            if (zero) begin
                m_act = '0; m_cnt = '0; m_tk = 0;
            end else if (m_act == 0) begin
                m_act = {m_hi, m_lo}; m_cnt = '0; m_tk = 0;
            end else if (baud_ce) begin
                if (m_cnt == m_act - 1) begin
                    m_tk = 1; m_cnt = '0; m_act = {m_hi, m_lo};
                end else begin
                    m_tk = 0; m_cnt = m_cnt + 1;
                end
            end else m_tk = 0;
            if (bus_we && dl_access && bus_addr == 3'd0) m_lo = bus_wdata;
            if (bus_we && dl_access && bus_addr == 3'd1) m_hi = bus_wdata;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_ticks(input string req);
        chk({req, " x16_tick"}, {7'd0, x16_tick}, {7'd0, m_tk});
        chk("R9 bit_tick", {7'd0, bit_tick}, {7'd0, exp_bit()});
    endtask

    // One cycle: drive at negedge, compare after the edge.
    task automatic cycle(input logic ce, input logic we, input logic acc,
                         input logic [2:0] a, input logic [7:0] d, input string req);
        baud_ce = ce; bus_we = we; dl_access = acc; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        chk_ticks(req);
    endtask

    task automatic read_chk(input logic acc, input logic [2:0] a, input string req);
        baud_ce = 0; bus_we = 0; dl_access = acc; bus_addr = a;
        ext_rdata = 8'($urandom);
        #1;
        chk(req, bus_rdata, exp_read(acc, a, ext_rdata));
    endtask

    initial begin
        void'($urandom(32'h1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1 x16_tick", {7'd0, x16_tick}, 8'd0);
        chk("R1 bit_tick", {7'd0, bit_tick}, 8'd0);
        read_chk(1, 3'd0, "R1 lo");
        chk("R1 lo value", bus_rdata, 8'h02);
        read_chk(1, 3'd1, "R1 hi");
        chk("R1 hi value", bus_rdata, 8'h00);
        // R4 pass-through
        read_chk(0, 3'd0, "R4 ofs0");
        read_chk(0, 3'd1, "R4 ofs1");
        read_chk(1, 3'd3, "R4 ofs3");
        // R5 default divisor 2
        for (int i = 0; i < 40; i++) cycle(1, 0, 0, 0, 0, "R5");
        // R3 ignored write
        @(negedge clk);
        cycle(0, 1, 0, 3'd0, 8'h77, "R3");
        read_chk(1, 3'd0, "R3 lo unchanged");
        chk("R3 lo value", bus_rdata, 8'h02);
        // R8 divisor 1
        cycle(0, 1, 1, 3'd0, 8'h01, "R2");
        read_chk(1, 3'd0, "R2 lo written");
        for (int i = 0; i < 40; i++) cycle(1, 0, 0, 0, 0, "R8");
        // R6 stop
        cycle(1, 1, 1, 3'd0, 8'h00, "R6");
        for (int i = 0; i < 20; i++) cycle(1, 0, 0, 0, 0, "R6");
        chk("R6 stopped", {7'd0, x16_tick}, 8'd0);
        // R7 restart
        cycle(0, 1, 1, 3'd0, 8'h03, "R7");
        for (int i = 0; i < 30; i++) cycle(1, 0, 0, 0, 0, "R7");
        // Random mix
        for (int i = 0; i < 4000; i++) begin
            logic we;
            logic [2:0] a;
            logic [7:0] d;
            we = ($urandom % 10) == 0;
            a = 3'($urandom % 3);
            d = (a == 3'd1) ? (($urandom % 8 == 0) ? 8'h01 : 8'h00) : 8'($urandom % 6);
            cycle(($urandom % 4) != 0, we, ($urandom % 4) != 0, a, d, "R5 R7");
            if (i % 50 == 0) read_chk(($urandom % 2) == 1, 3'($urandom % 4), "R2 R4 random");
        end
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule